// File: doc/BRIEF.md
# Tagged Capability Bus Width Adapter

This block sits between the load-store unit of a core and its memory bus. The core issues an access: a byte, halfword, word or capability. A capability is 64 data bits plus one validity tag. The adapter turns each access into bus transactions. The parameter `WIDE_BUS` selects the bus shape. When set, every bus beat carries 64 data bits and one tag bit, so a capability moves in a single atomic beat. When clear, every beat carries 32 data bits and one tag bit, so a capability moves as two beats.

In the 32-bit shape, each capability store half carries the capability's tag. A capability load yields the AND of the two returned tags. Any plain store writes a zero tag into the word it touches. Overwriting part of a capability with ordinary data therefore leaves the whole capability untagged when it is next loaded.

All data-carrying channels use valid/ready. A core request is accepted in a cycle where `req_valid` and `req_ready` are both high. `req_ready` is high only while no access is in flight, so one access is outstanding at a time. A bus request stays valid, with address, data, byte enables and tag unchanged, until `bus_req_ready` accepts it. The memory answers every accepted bus request, read or write, with exactly one `bus_rsp_valid` pulse, which the adapter always consumes. A core response stays valid, with unchanged payload, until `rsp_ready` is seen high.

Top module: `capbus_width_adapter`

## Requirements
- R1: With `WIDE_BUS`=1, a capability access uses exactly one bus transaction. That transaction is 8-byte aligned, has all 8 byte enables set, and carries the 64 data bits and the tag. Every plain access also uses exactly one bus transaction.
- R2: With `WIDE_BUS`=0, a capability access uses two bus transactions, one after the other. The first goes to the capability address and carries data bits 31:0. The second goes to that address plus 4 and carries bits 63:32. On a store, both beats carry the request's tag. The core response appears only after both beats complete.
- R3: With `WIDE_BUS`=0, a capability load returns {second beat data, first beat data} and a tag equal to the AND of the two returned tag bits.
- R4: Every plain store (size code 0, 1 or 2) writes tag 0 with its bus beat. This clears the tag of that bus word: the 32-bit word in the narrow shape, or the 64-bit word in the wide shape.
- R5: Plain stores are one 32-bit-lane beat with byte enables. Byte enable bit k covers byte address k of the lane. The size codes are: 0 byte, 1 halfword, 2 word, 3 capability.
  - Byte: enables only lane byte addr[1:0], with the data byte copied to every lane.
  - Halfword: enables bytes 0-1 when addr[1]=0 and bytes 2-3 when addr[1]=1, with the data halfword copied to both halves.
  - Word: enables all four bytes, and addr[1:0] is ignored.
  - In the wide shape, addr[2] places the lane in the upper 32 bits.
- R6: Plain loads return the addressed byte or halfword zero-extended (the word for size 2) in `rsp_rdata`. They return `rsp_rtag`=0 whatever tag the bus returns.
- R7: A capability access with addr[2:0] not zero is answered with `rsp_err`=1 and produces no bus transaction and no memory change.
- R8: Back-pressure.
  - A bus request held while `bus_req_ready` is low keeps its valid, address and data.
  - A response held while `rsp_ready` is low keeps its valid and data.
  - `req_ready` is low from acceptance until the response is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Core request valid |
| req_ready | output | 1 | Adapter can accept a request |
| req_write | input | 1 | 1 store, 0 load |
| req_size | input | 2 | 0 byte, 1 half, 2 word, 3 capability |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 64 | Store data, right-aligned for plain stores |
| req_wtag | input | 1 | Tag of a capability store |
| rsp_valid | output | 1 | Core response valid |
| rsp_ready | input | 1 | Core takes the response |
| rsp_rdata | output | 64 | Load data |
| rsp_rtag | output | 1 | Load tag |
| rsp_err | output | 1 | Misaligned capability access |
| bus_req_valid | output | 1 | Bus request valid |
| bus_req_ready | input | 1 | Bus accepts request |
| bus_req_write | output | 1 | Bus write |
| bus_req_addr | output | ADDR_W | Bus word address |
| bus_req_wdata | output | 32 or 64 | Bus write data |
| bus_req_be | output | 4 or 8 | Bus byte enables |
| bus_req_wtag | output | 1 | Bus write tag |
| bus_rsp_valid | input | 1 | Bus response valid |
| bus_rsp_rdata | input | 32 or 64 | Bus read data |
| bus_rsp_rtag | input | 1 | Bus read tag |

## Verification
The bench targets the case where a plain word store lands on half of a tagged capability. A design that forgot to zero the tag on plain stores, or that kept only one half's tag, would return that capability still tagged. The bench sweeps every byte and halfword offset of stores and loads. A wrong lane shift or enable mask would corrupt neighbouring bytes or return the wrong byte. Misaligned capability offsets 1 to 7 are all tried. A design that checked only addr[1:0] would let an offset of 4 through as two bus beats. Responses are held under back-pressure on both sides. A design that answered after the first narrow beat, or that let its payload change while stalled, would report a wrong beat count or unstable data.

// File: rtl/capbus_pkg.sv
package capbus_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_CAP  = 2'd3
  } acc_size_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_WAIT,
    ST_RESP
  } adp_state_e;

  localparam int CAP_DW  = 64;
  localparam int WORD_DW = 32;
endpackage

// File: rtl/capbus_wr_lanes.sv
module capbus_wr_lanes
  import capbus_pkg::*;
#(
  parameter bit WIDE_BUS = 1'b0,
  parameter int BUS_DW   = 32,
  parameter int BUS_BE   = 4
) (
  input  acc_size_e           size,
  input  logic [1:0]          addr_lo,
  input  logic                half_sel,
  input  logic [CAP_DW-1:0]   wdata,
  output logic [BUS_DW-1:0]   bus_wdata,
  output logic [BUS_BE-1:0]   bus_be
);
  logic [WORD_DW-1:0] lane_d;
  logic [3:0]         lane_be;
  logic               is_cap;

  assign is_cap = (size == SZ_CAP);

  // Place plain store data into the 32-bit lane
  always_comb begin
    unique case (size)
      SZ_BYTE: begin
        lane_d  = {4{wdata[7:0]}};
        lane_be = 4'b0001 << addr_lo;
      end
      SZ_HALF: begin
        lane_d  = {2{wdata[15:0]}};
        lane_be = addr_lo[1] ? 4'b1100 : 4'b0011;
      end
      default: begin
        lane_d  = wdata[WORD_DW-1:0];
        lane_be = 4'b1111;
      end
    endcase
  end

  generate
    if (WIDE_BUS) begin : g_wide
      always_comb begin
        if (is_cap) begin
          bus_wdata = wdata;
          bus_be    = '1;
        end else begin
          bus_wdata = {lane_d, lane_d};
          bus_be    = half_sel ? {lane_be, 4'b0000} : {4'b0000, lane_be};
        end
      end
    end else begin : g_narrow
      always_comb begin
        if (is_cap) begin
          bus_wdata = half_sel ? wdata[CAP_DW-1:WORD_DW] : wdata[WORD_DW-1:0];
          bus_be    = '1;
        end else begin
          bus_wdata = lane_d;
          bus_be    = lane_be;
        end
      end
    end
  endgenerate
endmodule

// File: rtl/capbus_rd_extract.sv
module capbus_rd_extract
  import capbus_pkg::*;
(
  input  acc_size_e            size,
  input  logic [1:0]           addr_lo,
  input  logic [WORD_DW-1:0]   word,
  output logic [CAP_DW-1:0]    plain_rdata
);
  logic [7:0]  sel_byte;
  logic [15:0] sel_half;

  always_comb begin
    sel_byte = word[8*addr_lo +: 8];
    sel_half = addr_lo[1] ? word[31:16] : word[15:0];
    unique case (size)
      SZ_BYTE: plain_rdata = {56'd0, sel_byte};
      SZ_HALF: plain_rdata = {48'd0, sel_half};
      default: plain_rdata = {32'd0, word};
    endcase
  end
endmodule

// File: rtl/capbus_width_adapter.sv
module capbus_width_adapter
  import capbus_pkg::*;
#(
  parameter bit WIDE_BUS = 1'b0,
  parameter int ADDR_W   = 32,
  localparam int BUS_DW  = WIDE_BUS ? 64 : 32,
  localparam int BUS_BE  = BUS_DW / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [1:0]        req_size,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [63:0]       req_wdata,
  input  logic              req_wtag,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [63:0]       rsp_rdata,
  output logic              rsp_rtag,
  output logic              rsp_err,
  output logic              bus_req_valid,
  input  logic              bus_req_ready,
  output logic              bus_req_write,
  output logic [ADDR_W-1:0] bus_req_addr,
  output logic [BUS_DW-1:0] bus_req_wdata,
  output logic [BUS_BE-1:0] bus_req_be,
  output logic              bus_req_wtag,
  input  logic              bus_rsp_valid,
  input  logic [BUS_DW-1:0] bus_rsp_rdata,
  input  logic              bus_rsp_rtag
);
  adp_state_e         state;
  acc_size_e          r_size;
  logic               r_write;
  logic [ADDR_W-1:0]  r_addr;
  logic [CAP_DW-1:0]  r_wdata;
  logic               r_wtag;
  logic               beat;
  logic [WORD_DW-1:0] lo_q;
  logic               tag_lo_q;
  logic               is_cap;
  logic               half_sel;
  logic               split_first;
  logic [WORD_DW-1:0] rd_word;
  logic [CAP_DW-1:0]  plain_rdata;
  logic [CAP_DW-1:0]  cap_rdata;
  logic               cap_rtag;
  acc_size_e          in_size;

  assign in_size  = acc_size_e'(req_size);
  assign is_cap   = (r_size == SZ_CAP);

  assign req_ready     = (state == ST_IDLE);
  assign bus_req_valid = (state == ST_ISSUE);
  assign rsp_valid     = (state == ST_RESP);
  assign bus_req_write = r_write;
  assign bus_req_wtag  = r_write & is_cap & r_wtag;

  generate
    if (WIDE_BUS) begin : g_wide
      assign half_sel     = r_addr[2];
      assign split_first  = 1'b0;
      assign bus_req_addr = {r_addr[ADDR_W-1:3], 3'b000};
      assign rd_word      = r_addr[2] ? bus_rsp_rdata[63:32] : bus_rsp_rdata[31:0];
      assign cap_rdata    = bus_rsp_rdata;
      assign cap_rtag     = bus_rsp_rtag;
    end else begin : g_narrow
      assign half_sel     = beat;
      assign split_first  = is_cap & ~beat;
      assign bus_req_addr = {r_addr[ADDR_W-1:3], r_addr[2] | beat, 2'b00};
      assign rd_word      = bus_rsp_rdata;
      assign cap_rdata    = {bus_rsp_rdata, lo_q};
      assign cap_rtag     = tag_lo_q & bus_rsp_rtag;
    end
  endgenerate

  capbus_wr_lanes #(
    .WIDE_BUS (WIDE_BUS),
    .BUS_DW   (BUS_DW),
    .BUS_BE   (BUS_BE)
  ) u_wr_lanes (
    .size      (r_size),
    .addr_lo   (r_addr[1:0]),
    .half_sel  (half_sel),
    .wdata     (r_wdata),
    .bus_wdata (bus_req_wdata),
    .bus_be    (bus_req_be)
  );

  capbus_rd_extract u_rd_extract (
    .size        (r_size),
    .addr_lo     (r_addr[1:0]),
    .word        (rd_word),
    .plain_rdata (plain_rdata)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      r_size    <= SZ_BYTE;
      r_write   <= 1'b0;
      r_addr    <= '0;
      r_wdata   <= '0;
      r_wtag    <= 1'b0;
      beat      <= 1'b0;
      lo_q      <= '0;
      tag_lo_q  <= 1'b0;
      rsp_rdata <= '0;
      rsp_rtag  <= 1'b0;
      rsp_err   <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: if (req_valid) begin
          r_size  <= in_size;
          r_write <= req_write;
          r_addr  <= req_addr;
          r_wdata <= req_wdata;
          r_wtag  <= req_wtag;
          beat    <= 1'b0;
          if (in_size == SZ_CAP && req_addr[2:0] != 3'b000) begin
            rsp_err   <= 1'b1;
            rsp_rdata <= '0;
            rsp_rtag  <= 1'b0;
            state     <= ST_RESP;
          end else begin
            rsp_err <= 1'b0;
            state   <= ST_ISSUE;
          end
        end
        ST_ISSUE: if (bus_req_ready) state <= ST_WAIT;
        ST_WAIT: if (bus_rsp_valid) begin
          if (split_first) begin
            lo_q     <= bus_rsp_rdata[WORD_DW-1:0];
            tag_lo_q <= bus_rsp_rtag;
            beat     <= 1'b1;
            state    <= ST_ISSUE;
          end else begin
            state <= ST_RESP;
            if (r_write) begin
              rsp_rdata <= '0;
              rsp_rtag  <= 1'b0;
            end else if (is_cap) begin
              rsp_rdata <= cap_rdata;
              rsp_rtag  <= cap_rtag;
            end else begin
              rsp_rdata <= plain_rdata;
              rsp_rtag  <= 1'b0;
            end
          end
        end
        ST_RESP: if (rsp_ready) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  // Observation registers for the properties below
  logic [1:0]        ck_beats;
  logic [ADDR_W-1:0] ck_first_addr;
  logic              ck_tag_and;
  logic              ck_is_cap;
  logic              ck_req_tag;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ck_beats      <= '0;
      ck_first_addr <= '0;
      ck_tag_and    <= 1'b1;
      ck_is_cap     <= 1'b0;
      ck_req_tag    <= 1'b0;
    end else if (req_valid && req_ready) begin
      ck_beats   <= '0;
      ck_tag_and <= 1'b1;
      ck_is_cap  <= (req_size == 2'd3);
      ck_req_tag <= req_wtag;
    end else begin
      if (bus_req_valid && bus_req_ready) begin
        ck_beats <= ck_beats + 2'd1;
        if (ck_beats == 2'd0) ck_first_addr <= bus_req_addr;
      end
      if (bus_rsp_valid) ck_tag_and <= ck_tag_and & bus_rsp_rtag;
    end
  end

  p_one_beat_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_err && !(ck_is_cap && !WIDE_BUS) |-> ck_beats == 2'd1);
  p_two_beats_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_err && ck_is_cap && !WIDE_BUS |-> ck_beats == 2'd2);
  p_upper_second_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req_valid && ck_beats == 2'd1 |-> bus_req_addr == ck_first_addr + 4);
  p_cap_store_tag_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req_valid && bus_req_write && ck_is_cap |-> bus_req_wtag == ck_req_tag);
  p_tag_and_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_err && ck_is_cap && !r_write |-> rsp_rtag == ck_tag_and);
  p_plain_store_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req_valid && bus_req_write && !ck_is_cap |-> !bus_req_wtag);
  p_plain_load_tag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !ck_is_cap |-> !rsp_rtag);
  p_no_bus_on_err_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_err |-> ck_beats == 2'd0);
  p_bus_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req_valid && !bus_req_ready |=> bus_req_valid && $stable(bus_req_addr) && $stable(bus_req_wdata));
  p_rsp_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_rdata));
endmodule

// File: tb/cap_mem_model.sv
module cap_mem_model #(
  parameter int DW    = 32,
  parameter int DEPTH = 16
) (
  input  logic            clk,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic            write,
  input  logic [31:0]     addr,
  input  logic [DW-1:0]   wdata,
  input  logic [DW/8-1:0] be,
  input  logic            wtag,
  output logic            rsp_valid,
  output logic [DW-1:0]   rsp_rdata,
  output logic            rsp_rtag
);
  localparam int LB = $clog2(DW / 8);
  localparam int IW = $clog2(DEPTH);

  logic [DW-1:0] data [DEPTH];
  logic          tag  [DEPTH];
  logic [31:0]   log_addr [4];
  logic          log_tag  [4];
  int            tx_count;
  logic [7:0]    lfsr;
  logic [IW-1:0] idx;

  assign idx       = addr[LB +: IW];
  assign req_ready = lfsr[0] | lfsr[2];

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      data[i] = '0;
      tag[i]  = 1'b0;
    end
    tx_count  = 0;
    lfsr      = 8'h5B;
    rsp_valid = 1'b0;
    rsp_rdata = '0;
    rsp_rtag  = 1'b0;
  end

  always @(posedge clk) begin
    lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    if (req_valid && req_ready) begin
      log_addr[tx_count % 4] <= addr;
      log_tag[tx_count % 4]  <= wtag;
      tx_count  <= tx_count + 1;
      rsp_valid <= 1'b1;
      rsp_rdata <= data[idx];
      rsp_rtag  <= tag[idx];
      if (write) begin
        for (int b = 0; b < DW / 8; b++)
          if (be[b]) data[idx][8*b +: 8] <= wdata[8*b +: 8];
        tag[idx] <= wtag;
      end
    end else begin
      rsp_valid <= 1'b0;
    end
  end
endmodule

// File: tb/capbus_width_adapter_test.sv
module capbus_width_adapter_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        req_valid [2];
  logic        req_ready [2];
  logic        req_write [2];
  logic [1:0]  req_size  [2];
  logic [31:0] req_addr  [2];
  logic [63:0] req_wdata [2];
  logic        req_wtag  [2];
  logic        rsp_valid [2];
  logic        rsp_ready [2];
  logic [63:0] rsp_rdata [2];
  logic        rsp_rtag  [2];
  logic        rsp_err   [2];

  logic n_bv, n_br, n_bw, n_bt, n_rv, n_rt;
  logic [31:0] n_ba, n_bd, n_rd;
  logic [3:0]  n_be;
  logic w_bv, w_br, w_bw, w_bt, w_rv, w_rt;
  logic [31:0] w_ba;
  logic [63:0] w_bd, w_rd;
  logic [7:0]  w_be;

  capbus_width_adapter #(.WIDE_BUS(1'b0)) uut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid[0]), .req_ready(req_ready[0]), .req_write(req_write[0]),
    .req_size(req_size[0]), .req_addr(req_addr[0]), .req_wdata(req_wdata[0]),
    .req_wtag(req_wtag[0]), .rsp_valid(rsp_valid[0]), .rsp_ready(rsp_ready[0]),
    .rsp_rdata(rsp_rdata[0]), .rsp_rtag(rsp_rtag[0]), .rsp_err(rsp_err[0]),
    .bus_req_valid(n_bv), .bus_req_ready(n_br), .bus_req_write(n_bw),
    .bus_req_addr(n_ba), .bus_req_wdata(n_bd), .bus_req_be(n_be), .bus_req_wtag(n_bt),
    .bus_rsp_valid(n_rv), .bus_rsp_rdata(n_rd), .bus_rsp_rtag(n_rt));

  cap_mem_model #(.DW(32)) mn (
    .clk(clk), .req_valid(n_bv), .req_ready(n_br), .write(n_bw), .addr(n_ba),
    .wdata(n_bd), .be(n_be), .wtag(n_bt), .rsp_valid(n_rv), .rsp_rdata(n_rd),
    .rsp_rtag(n_rt));

  capbus_width_adapter #(.WIDE_BUS(1'b1)) uut_w (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid[1]), .req_ready(req_ready[1]), .req_write(req_write[1]),
    .req_size(req_size[1]), .req_addr(req_addr[1]), .req_wdata(req_wdata[1]),
    .req_wtag(req_wtag[1]), .rsp_valid(rsp_valid[1]), .rsp_ready(rsp_ready[1]),
    .rsp_rdata(rsp_rdata[1]), .rsp_rtag(rsp_rtag[1]), .rsp_err(rsp_err[1]),
    .bus_req_valid(w_bv), .bus_req_ready(w_br), .bus_req_write(w_bw),
    .bus_req_addr(w_ba), .bus_req_wdata(w_bd), .bus_req_be(w_be), .bus_req_wtag(w_bt),
    .bus_rsp_valid(w_rv), .bus_rsp_rdata(w_rd), .bus_rsp_rtag(w_rt));

  cap_mem_model #(.DW(64)) mw (
    .clk(clk), .req_valid(w_bv), .req_ready(w_br), .write(w_bw), .addr(w_ba),
    .wdata(w_bd), .be(w_be), .wtag(w_bt), .rsp_valid(w_rv), .rsp_rdata(w_rd),
    .rsp_rtag(w_rt));

  int checks = 0;
  int fails  = 0;

  logic [31:0] sn_d [16];
  logic        sn_t [16];
  logic [63:0] sw_d [16];
  logic        sw_t [16];

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] pat(input int i);
    return {32'hA5000000 + 32'(i) * 32'h01010101, 32'h3C000000 ^ (32'(i) * 32'h00110011)};
  endfunction

  function automatic logic [31:0] merge32(input logic [31:0] old, input logic [1:0] sz,
                                          input logic [1:0] off, input logic [31:0] wd);
    logic [31:0] r;
    r = old;
    for (int k = 0; k < 4; k++) begin
      bit hit;
      logic [7:0] src;
      hit = (sz == 2) || (sz == 0 && k == int'(off)) || (sz == 1 && (k / 2) == int'(off[1]));
      src = (sz == 0) ? wd[7:0] : (sz == 1) ? wd[8*(k%2) +: 8] : wd[8*k +: 8];
      if (hit) r[8*k +: 8] = src;
    end
    return r;
  endfunction

  function automatic logic [63:0] extract(input logic [31:0] w, input logic [1:0] sz, input logic [1:0] off);
    if (sz == 0) return 64'((w >> (8 * int'(off))) & 32'hFF);
    if (sz == 1) return off[1] ? 64'(w[31:16]) : 64'(w[15:0]);
    return 64'(w);
  endfunction

  task automatic acc(input int m, input bit wr, input logic [1:0] sz, input logic [31:0] a,
                     input logic [63:0] wd, input bit tg, input int hold,
                     output logic [63:0] rd, output bit rt, output bit er, output int nb);
    int c0;
    c0 = (m == 0) ? mn.tx_count : mw.tx_count;
    req_write[m] = wr; req_size[m] = sz; req_addr[m] = a;
    req_wdata[m] = wd; req_wtag[m] = tg; req_valid[m] = 1'b1;
    rsp_ready[m] = (hold == 0);
    while (!req_ready[m]) @(negedge clk);
    @(negedge clk);
    req_valid[m] = 1'b0;
    while (!rsp_valid[m]) @(negedge clk);
    nb = ((m == 0) ? mn.tx_count : mw.tx_count) - c0;
    rd = rsp_rdata[m]; rt = rsp_rtag[m]; er = rsp_err[m];
    if (hold > 0) begin
      repeat (hold) @(negedge clk);
      check(rsp_valid[m] && rsp_rdata[m] == rd, "R8", rsp_rdata[m], rd);
      rsp_ready[m] = 1'b1;
    end
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [63:0] rd;
    bit rt, er;
    int nb, c0;
    logic [31:0] dsave;
    for (int m = 0; m < 2; m++) begin
      req_valid[m] = 0; req_write[m] = 0; req_size[m] = 0; req_addr[m] = 0;
      req_wdata[m] = 0; req_wtag[m] = 0; rsp_ready[m] = 1;
    end
    for (int i = 0; i < 16; i++) begin
      sn_d[i] = 0; sn_t[i] = 0; sw_d[i] = 0; sw_t[i] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state
    check(req_ready[0] && !rsp_valid[0] && !n_bv, "R8", {61'd0, req_ready[0], rsp_valid[0], n_bv}, 64'h4);
    check(req_ready[1] && !rsp_valid[1] && !w_bv, "R8", {61'd0, req_ready[1], rsp_valid[1], w_bv}, 64'h4);

    // R2: narrow capability stores, lower half first, tag on both halves
    for (int i = 0; i < 8; i++) begin
      bit tg;
      tg = (i % 3) != 0;
      c0 = mn.tx_count;
      acc(0, 1, 2'd3, 32'(i * 8), pat(i), tg, 0, rd, rt, er, nb);
      check(nb == 2 && !er, "R2", 64'(nb), 64'd2);
      check(mn.log_addr[c0 % 4] == 32'(i * 8) && mn.log_addr[(c0 + 1) % 4] == 32'(i * 8 + 4),
            "R2", {mn.log_addr[c0 % 4], mn.log_addr[(c0 + 1) % 4]}, {32'(i * 8), 32'(i * 8 + 4)});
      check(mn.log_tag[c0 % 4] == tg && mn.log_tag[(c0 + 1) % 4] == tg, "R2",
            {mn.log_tag[c0 % 4], mn.log_tag[(c0 + 1) % 4]}, {tg, tg});
      sn_d[2*i] = pat(i)[31:0]; sn_d[2*i+1] = pat(i)[63:32];
      sn_t[2*i] = tg; sn_t[2*i+1] = tg;
    end
    // R3: capability loads, one with response back-pressure
    for (int i = 0; i < 8; i++) begin
      acc(0, 0, 2'd3, 32'(i * 8), 64'd0, 0, (i == 5) ? 3 : 0, rd, rt, er, nb);
      check(rd == {sn_d[2*i+1], sn_d[2*i]}, "R3", rd, {sn_d[2*i+1], sn_d[2*i]});
      check(rt == (sn_t[2*i] & sn_t[2*i+1]), "R3", 64'(rt), 64'(sn_t[2*i] & sn_t[2*i+1]));
      check(nb == 2, "R2", 64'(nb), 64'd2);
    end
    // R4: plain word store over upper half of tagged dword 1
    acc(0, 1, 2'd2, 32'd12, 64'hDEADBEEF, 1, 0, rd, rt, er, nb);
    sn_d[3] = 32'hDEADBEEF; sn_t[3] = 0;
    check(mn.tag[3] == 0 && mn.tag[2] == 1, "R4", {mn.tag[3], mn.tag[2]}, 64'b01);
    acc(0, 0, 2'd3, 32'd8, 64'd0, 0, 0, rd, rt, er, nb);
    check(rt == 0 && rd == {sn_d[3], sn_d[2]}, "R3", {rd[62:0], rt}, {sn_d[3], sn_d[2][30:0], 1'b0});
    // R5: sub-word store sweep on words 4 and 5, word store with offset on word 6
    for (int o = 0; o < 4; o++) begin
      acc(0, 1, 2'd0, 32'(16 + o), 64'(8'h10 + o), 0, 0, rd, rt, er, nb);
      sn_d[4] = merge32(sn_d[4], 2'd0, 2'(o), 32'(8'h10 + o)); sn_t[4] = 0;
      check(mn.data[4] == sn_d[4], "R5", 64'(mn.data[4]), 64'(sn_d[4]));
    end
    check(mn.tag[4] == 0, "R4", 64'(mn.tag[4]), 64'd0);
    for (int o = 0; o < 4; o += 2) begin
      acc(0, 1, 2'd1, 32'(20 + o), 64'(16'hB00 + o), 0, 0, rd, rt, er, nb);
      sn_d[5] = merge32(sn_d[5], 2'd1, 2'(o), 32'(16'hB00 + o)); sn_t[5] = 0;
      check(mn.data[5] == sn_d[5], "R5", 64'(mn.data[5]), 64'(sn_d[5]));
    end
    acc(0, 1, 2'd2, 32'd25, 64'h01234567, 0, 0, rd, rt, er, nb);
    sn_d[6] = 32'h01234567; sn_t[6] = 0;
    check(mn.data[6] == sn_d[6], "R5", 64'(mn.data[6]), 64'(sn_d[6]));
    // R6: plain load sweep over all words, sizes and offsets
    for (int w = 0; w < 16; w++)
      for (int sz = 0; sz < 3; sz++)
        for (int o = 0; o < 4; o++) begin
          acc(0, 0, 2'(sz), 32'(w * 4 + o), 64'd0, 0, 0, rd, rt, er, nb);
          check(rd == extract(sn_d[w], 2'(sz), 2'(o)), "R6", rd, extract(sn_d[w], 2'(sz), 2'(o)));
          check(rt == 0 && nb == 1, "R6", {rt, 62'(nb)}, 64'd1);
        end
    // R7: misaligned capability accesses
    dsave = mn.data[14];
    for (int o = 1; o < 8; o++) begin
      acc(0, o[0], 2'd3, 32'(56 + o), 64'hFFFF_FFFF_FFFF_FFFF, 1, 0, rd, rt, er, nb);
      check(er == 1 && nb == 0, "R7", {er, 62'(nb)}, {1'b1, 62'd0});
    end
    check(mn.data[14] == dsave && mn.tag[14] == sn_t[14], "R7", 64'(mn.data[14]), 64'(dsave));

    // R1: wide capability stores and loads
    for (int i = 0; i < 4; i++) begin
      bit tg;
      tg = (i % 2) == 1;
      c0 = mw.tx_count;
      acc(1, 1, 2'd3, 32'(i * 8), pat(i + 8), tg, 0, rd, rt, er, nb);
      check(nb == 1 && mw.log_tag[c0 % 4] == tg && mw.log_addr[c0 % 4] == 32'(i * 8), "R1",
            64'(nb), 64'd1);
      check(mw.data[i] == pat(i + 8), "R1", mw.data[i], pat(i + 8));
      sw_d[i] = pat(i + 8); sw_t[i] = tg;
      acc(1, 0, 2'd3, 32'(i * 8), 64'd0, 0, 0, rd, rt, er, nb);
      check(rd == sw_d[i] && rt == tg && nb == 1, "R1", rd, sw_d[i]);
    end
    // R4 wide: plain word store to upper half of tagged dword 1
    acc(1, 1, 2'd2, 32'd12, 64'h0BADF00D, 0, 0, rd, rt, er, nb);
    sw_d[1][63:32] = 32'h0BADF00D; sw_t[1] = 0;
    check(mw.tag[1] == 0 && mw.data[1] == sw_d[1], "R4", mw.data[1], sw_d[1]);
    // R5 wide: byte store into upper half of dword 2
    acc(1, 1, 2'd0, 32'd21, 64'h77, 0, 0, rd, rt, er, nb);
    sw_d[2][63:32] = merge32(sw_d[2][63:32], 2'd0, 2'd1, 32'h77); sw_t[2] = 0;
    check(mw.data[2] == sw_d[2], "R5", mw.data[2], sw_d[2]);
    // R6 wide: plain loads on both halves, tags ignored
    for (int d = 0; d < 4; d++)
      for (int h = 0; h < 2; h++)
        for (int sz = 0; sz < 3; sz++)
          for (int o = 0; o < 4; o++) begin
            logic [31:0] wv;
            wv = h ? sw_d[d][63:32] : sw_d[d][31:0];
            acc(1, 0, 2'(sz), 32'(d * 8 + h * 4 + o), 64'd0, 0, 0, rd, rt, er, nb);
            check(rd == extract(wv, 2'(sz), 2'(o)) && rt == 0, "R6", rd, extract(wv, 2'(sz), 2'(o)));
          end
    // R7 wide: offset 4 is misaligned too
    acc(1, 0, 2'd3, 32'd4, 64'd0, 0, 0, rd, rt, er, nb);
    check(er == 1 && nb == 0, "R7", {er, 62'(nb)}, {1'b1, 62'd0});

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule